// File: doc/BRIEF.md
# Flash Line Buffer Allocation Controller

This block controls a small set of line read buffers placed in front of a flash array. Each accepted request carries a line address, a read/write flag, an instruction/data flag and a master number. The block compares the address with the tags of the buffers that the current split assigns to that access type.

A read that hits is answered from that buffer. A read that misses claims a victim buffer and raises a line fill request toward the array. The fill request is held until the array acknowledges it. After a read hit, the block can also fetch the next sequential line ahead of demand, provided every enable in the control inputs allows it.

The block keeps a state and an age rank for every buffer. A buffer loaded by a demand miss becomes most-recently-used when its data arrives. A buffer loaded ahead of demand keeps its rank until a later access hits it.

The request port is valid/ready. The block drops `req_ready` while a fill is outstanding, and for the one cycle in which a buffer is serving a read hit. A request is taken only on a clock edge where both `req_valid` and `req_ready` are high. The requester must hold its request steady until then. The fill port is also valid/ready: `fill_valid` together with the line address, buffer index and prefetch flag stays stable until the edge on which `fill_ready` is seen high.

Top module: `flb_alloc`

## Requirements
- R1: After reset, every buffer is in state 0 (invalid), buffer i has age rank i, `req_ready` is 1, and `fill_valid` and `resp_valid` are 0.
- R2: One cycle after an accepted read whose line address matches the tag of an assigned buffer in state 1 (valid), 2 (prefetched) or 3 (serving), `resp_valid`=1, `resp_hit`=1 and `resp_buf` gives that buffer. For that one cycle the buffer is in state 3, and then it returns to state 1.
- R3: On a read miss, the lowest-numbered assigned buffer in state 0 is chosen as the victim.
- R4: When no assigned buffer is invalid, the victim is the assigned, non-busy buffer with the highest age rank. Buffers outside the access type's partition are not considered.
- R5: One cycle after a read miss, `resp_hit`=0 and `resp_buf` is the victim. `fill_valid`=1 carries the line address, the victim index and `fill_pf`=0. The victim is in state 4 (filling). On the `fill_ready` edge, the buffer moves to state 1 with rank 0.
- R6: Promoting a buffer to rank 0 adds one to the rank of every buffer whose rank was lower than its old rank. All other ranks are unchanged, so the ranks always form a permutation. A read hit and a demand fill completion each promote.
- R7: After a read hit with prefetch allowed, if the next line (address+1) is not already in an assigned buffer, a fill for address+1 is raised with `fill_pf`=1. The victim is chosen as in R3/R4, with the hit buffer excluded. If no victim is left, no fill is raised. On acknowledge, the buffer enters state 2 and its rank is unchanged; a later hit promotes it.
- R8: Prefetch is allowed only when `cfg_buf_en`=1, `cfg_pf_limit`≠0, `cfg_ipf_en` (for instruction access) or `cfg_dpf_en` (for data access) is 1, and bit `req_master` of `cfg_mst_pf` is 1.
- R9: Writes never raise a fill. A write hit answers `resp_hit`=1 and puts the hit buffer in state 0. A write miss answers `resp_hit`=0 and changes no buffer.
- R10: The `cfg_split` field assigns buffers. With 0 (and 3), all buffers serve both types. With 1, the lower half of the buffers serve instructions and the upper half serve data. With 2, every buffer but the last serves instructions and the last buffer serves data. A buffer outside the partition never hits.
- R11: `req_ready` is 0 whenever `fill_valid` is 1 or any buffer is in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW | Line address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_instr | input | 1 | 1 = instruction access, 0 = data |
| req_master | input | clog2(NMST) | Requesting master number |
| resp_valid | output | 1 | Lookup result present |
| resp_hit | output | 1 | Lookup hit |
| resp_buf | output | clog2(NBUF) | Hit buffer or victim |
| cfg_split | input | 2 | Buffer partition mode |
| cfg_buf_en | input | 1 | Buffer enable |
| cfg_pf_limit | input | 2 | Prefetch limit, 0 disables prefetch |
| cfg_ipf_en | input | 1 | Prefetch on instruction access |
| cfg_dpf_en | input | 1 | Prefetch on data access |
| cfg_mst_pf | input | NMST | Per-master prefetch enable |
| fill_valid | output | 1 | Line fill requested |
| fill_ready | input | 1 | Array acknowledges fill |
| fill_addr | output | AW | Line to fill |
| fill_buf | output | clog2(NBUF) | Buffer being filled |
| fill_pf | output | 1 | Fill is a prefetch |
| buf_state | output | 3*NBUF | State of buffer i at bits [3i+2:3i] |
| buf_age | output | clog2(NBUF)*NBUF | Age rank of buffer i, 0 = most recent |

## Verification
A request is accepted at a rising edge. The response, the fill request, the new buffer state and a hit's promotion are all visible right after that same edge. The bench therefore drives at a falling edge and samples at the next falling edge. A fill completes on the edge where `fill_ready` is high. The state change to 1 or 2, and the demand promotion, are sampled at the falling edge after it. The bench waits for `req_ready` before driving, so the one-cycle serving hold after a hit and an outstanding fill both delay the next request and are never sampled as a lost request.

// File: rtl/flb_pkg.sv
package flb_pkg;
  typedef enum logic [2:0] {
    BS_INVALID = 3'd0,
    BS_VALID   = 3'd1,
    BS_PREF    = 3'd2,
    BS_SERVING = 3'd3,
    BS_FILLING = 3'd4
  } buf_state_e;

  // Is buffer idx assigned to this access type under the split mode?
  function automatic logic in_part(input int idx, input int nbuf,
                                   input logic instr, input logic [1:0] split);
    case (split)
      2'd1:    return instr ? (idx < nbuf / 2) : (idx >= nbuf / 2);
      2'd2:    return instr ? (idx < nbuf - 1) : (idx == nbuf - 1);
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/flb_match.sv
module flb_match
  import flb_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int AW   = 16
) (
  input  logic [NBUF-1:0][2:0]    st,
  input  logic [NBUF-1:0][AW-1:0] tags,
  input  logic [NBUF-1:0]         elig,
  input  logic [AW-1:0]           addr,
  output logic [NBUF-1:0]         hit_mask
);
  for (genvar i = 0; i < NBUF; i++) begin : g_cmp
    assign hit_mask[i] = elig[i] && (tags[i] == addr) &&
                         (st[i] == BS_VALID || st[i] == BS_PREF || st[i] == BS_SERVING);
  end
endmodule

// File: rtl/flb_victim.sv
module flb_victim
  import flb_pkg::*;
#(
  parameter int NBUF = 4,
  localparam int IW = $clog2(NBUF),
  localparam int RW = $clog2(NBUF)
) (
  input  logic [NBUF-1:0][2:0]    st,
  input  logic [NBUF-1:0][RW-1:0] ages,
  input  logic [NBUF-1:0]         elig,
  input  logic [NBUF-1:0]         excl,
  output logic                    vic_ok,
  output logic [IW-1:0]           vic_idx
);
  logic [NBUF-1:0] cand;
  logic            inv_found;
  logic [RW-1:0]   best_age;

  for (genvar i = 0; i < NBUF; i++) begin : g_cand
    assign cand[i] = elig[i] && !excl[i] &&
                     (st[i] == BS_INVALID || st[i] == BS_VALID || st[i] == BS_PREF);
  end

  always_comb begin
    vic_ok    = 1'b0;
    vic_idx   = '0;
    inv_found = 1'b0;
    best_age  = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (cand[i] && st[i] == BS_INVALID && !inv_found) begin
        inv_found = 1'b1;
        vic_ok    = 1'b1;
        vic_idx   = IW'(i);
      end
    end
    if (!inv_found) begin
      for (int i = 0; i < NBUF; i++) begin
        if (cand[i] && (!vic_ok || ages[i] > best_age)) begin
          vic_ok   = 1'b1;
          vic_idx  = IW'(i);
          best_age = ages[i];
        end
      end
    end
  end
endmodule

// File: rtl/flb_recency.sv
module flb_recency #(
  parameter int NBUF = 4,
  localparam int IW = $clog2(NBUF),
  localparam int RW = $clog2(NBUF)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    promote,
  input  logic [IW-1:0]           promote_idx,
  output logic [NBUF-1:0][RW-1:0] ages
);
  logic [RW-1:0] pivot;
  assign pivot = ages[promote_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) ages[i] <= RW'(i);
    end else if (promote) begin
      for (int i = 0; i < NBUF; i++) begin
        if (IW'(i) == promote_idx)  ages[i] <= '0;
        else if (ages[i] < pivot)   ages[i] <= ages[i] + RW'(1);
      end
    end
  end
endmodule

// File: rtl/flb_alloc.sv
module flb_alloc
  import flb_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int AW   = 16,
  parameter int NMST = 4,
  localparam int IW = $clog2(NBUF),
  localparam int RW = $clog2(NBUF),
  localparam int MW = $clog2(NMST)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  input  logic                 req_write,
  input  logic                 req_instr,
  input  logic [MW-1:0]        req_master,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output logic [IW-1:0]        resp_buf,
  input  logic [1:0]           cfg_split,
  input  logic                 cfg_buf_en,
  input  logic [1:0]           cfg_pf_limit,
  input  logic                 cfg_ipf_en,
  input  logic                 cfg_dpf_en,
  input  logic [NMST-1:0]      cfg_mst_pf,
  output logic                 fill_valid,
  input  logic                 fill_ready,
  output logic [AW-1:0]        fill_addr,
  output logic [IW-1:0]        fill_buf,
  output logic                 fill_pf,
  output logic [3*NBUF-1:0]    buf_state,
  output logic [RW*NBUF-1:0]   buf_age
);
  logic [NBUF-1:0][2:0]    st_q;
  logic [NBUF-1:0][AW-1:0] tag_q;
  logic [NBUF-1:0][RW-1:0] ages;
  logic [NBUF-1:0]         elig, hm_cur, hm_nxt, serving;
  logic [AW-1:0]           nxt_addr;
  logic                    hit_c, miss_ok, pf_vic_ok, pf_ok;
  logic [IW-1:0]           hit_idx, miss_vic, pf_vic;
  logic                    acc, do_miss, do_pf, fill_done, promote;
  logic [IW-1:0]           promote_idx;

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    assign elig[i]              = in_part(i, NBUF, req_instr, cfg_split);
    assign serving[i]           = (st_q[i] == BS_SERVING);
    assign buf_state[3*i +: 3]  = st_q[i];
    assign buf_age[RW*i +: RW]  = ages[i];
  end

  assign nxt_addr = req_addr + AW'(1);

  flb_match #(.NBUF(NBUF), .AW(AW)) u_match_cur (
    .st(st_q), .tags(tag_q), .elig(elig), .addr(req_addr), .hit_mask(hm_cur));
  flb_match #(.NBUF(NBUF), .AW(AW)) u_match_nxt (
    .st(st_q), .tags(tag_q), .elig(elig), .addr(nxt_addr), .hit_mask(hm_nxt));
  flb_victim #(.NBUF(NBUF)) u_vic_miss (
    .st(st_q), .ages(ages), .elig(elig), .excl('0), .vic_ok(miss_ok), .vic_idx(miss_vic));
  flb_victim #(.NBUF(NBUF)) u_vic_pf (
    .st(st_q), .ages(ages), .elig(elig), .excl(hm_cur), .vic_ok(pf_vic_ok), .vic_idx(pf_vic));

  always_comb begin
    hit_idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) if (hm_cur[i]) hit_idx = IW'(i);
  end
  assign hit_c = |hm_cur;

  assign req_ready = !fill_valid && !(|serving);
  assign acc       = req_valid && req_ready;
  assign pf_ok     = cfg_buf_en && (cfg_pf_limit != 2'd0) &&
                     (req_instr ? cfg_ipf_en : cfg_dpf_en) &&
                     cfg_mst_pf[req_master] && !req_write;
  assign do_miss   = acc && !req_write && !hit_c && miss_ok;
  assign do_pf     = acc && hit_c && pf_ok && !(|hm_nxt) && pf_vic_ok;
  assign fill_done = fill_valid && fill_ready;

  assign promote     = (acc && hit_c && !req_write) || (fill_done && !fill_pf);
  assign promote_idx = fill_done ? fill_buf : hit_idx;

  flb_recency #(.NBUF(NBUF)) u_rec (
    .clk(clk), .rst_n(rst_n), .promote(promote), .promote_idx(promote_idx), .ages(ages));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) begin
        st_q[i]  <= BS_INVALID;
        tag_q[i] <= '0;
      end
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_buf   <= '0;
      fill_valid <= 1'b0;
      fill_addr  <= '0;
      fill_buf   <= '0;
      fill_pf    <= 1'b0;
    end else begin
      resp_valid <= acc;
      for (int i = 0; i < NBUF; i++)
        if (st_q[i] == BS_SERVING) st_q[i] <= BS_VALID;
      if (fill_done) begin
        st_q[fill_buf]  <= fill_pf ? BS_PREF : BS_VALID;
        tag_q[fill_buf] <= fill_addr;
        fill_valid      <= 1'b0;
      end
      if (acc) begin
        resp_hit <= hit_c;
        resp_buf <= hit_c ? hit_idx : (do_miss ? miss_vic : '0);
        if (hit_c) st_q[hit_idx] <= req_write ? BS_INVALID : BS_SERVING;
      end
      if (do_miss) begin
        st_q[miss_vic] <= BS_FILLING;
        fill_valid     <= 1'b1;
        fill_addr      <= req_addr;
        fill_buf       <= miss_vic;
        fill_pf        <= 1'b0;
      end
      if (do_pf) begin
        st_q[pf_vic] <= BS_FILLING;
        fill_valid   <= 1'b1;
        fill_addr    <= nxt_addr;
        fill_buf     <= pf_vic;
        fill_pf      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flb_alloc_chk.sv
module flb_alloc_chk #(
  parameter int NBUF = 4,
  parameter int AW   = 16,
  localparam int IW = $clog2(NBUF),
  localparam int RW = $clog2(NBUF)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic               resp_valid,
  input logic               fill_valid,
  input logic               fill_ready,
  input logic [AW-1:0]      fill_addr,
  input logic [IW-1:0]      fill_buf,
  input logic [3*NBUF-1:0]  buf_state,
  input logic [RW*NBUF-1:0] buf_age
);
  logic [NBUF-1:0] rank_seen;
  logic [NBUF-1:0] serving;
  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < NBUF; i++) begin
      rank_seen[buf_age[RW*i +: RW]] = 1'b1;
      serving[i] = (buf_state[3*i +: 3] == 3'd3);
    end
  end

  a_r11_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || (|serving)) |-> !req_ready);

  a_r5_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_addr) && $stable(fill_buf)));

  a_r5_fill_target_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (buf_state[3*int'(fill_buf) +: 3] == 3'd4));

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid);

  a_r9_write_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !fill_valid);

  a_r6_rank_perm: assert property (@(posedge clk) disable iff (!rst_n)
    rank_seen == {NBUF{1'b1}});
endmodule

bind flb_alloc flb_alloc_chk #(.NBUF(NBUF), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .resp_valid(resp_valid), .fill_valid(fill_valid),
  .fill_ready(fill_ready), .fill_addr(fill_addr), .fill_buf(fill_buf),
  .buf_state(buf_state), .buf_age(buf_age));

// File: tb/tb_flb_alloc.sv
module tb_flb_alloc;
  localparam int NBUF = 4, AW = 16, NMST = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_instr = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_master = '0;
  logic resp_valid, resp_hit;
  logic [1:0] resp_buf;
  logic [1:0] cfg_split = 2'd0, cfg_pf_limit = 2'd0;
  logic cfg_buf_en = 1'b1, cfg_ipf_en = 1'b0, cfg_dpf_en = 1'b0;
  logic [NMST-1:0] cfg_mst_pf = '0;
  logic fill_valid, fill_ready = 1'b0, fill_pf;
  logic [AW-1:0] fill_addr;
  logic [1:0] fill_buf;
  logic [3*NBUF-1:0] buf_state;
  logic [2*NBUF-1:0] buf_age;
  int ntests = 0, nfail = 0;

  always #10 clk = ~clk;

  flb_alloc #(.NBUF(NBUF), .AW(AW), .NMST(NMST)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_instr(req_instr),
    .req_master(req_master), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_buf(resp_buf), .cfg_split(cfg_split), .cfg_buf_en(cfg_buf_en),
    .cfg_pf_limit(cfg_pf_limit), .cfg_ipf_en(cfg_ipf_en), .cfg_dpf_en(cfg_dpf_en),
    .cfg_mst_pf(cfg_mst_pf), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_addr(fill_addr), .fill_buf(fill_buf), .fill_pf(fill_pf),
    .buf_state(buf_state), .buf_age(buf_age));

  // vector: {write, addr[15:0], exp_hit, exp_buf[1:0], exp_fill}
  localparam logic [20:0] VEC [10] = '{
    {1'b0, 16'h0010, 1'b0, 2'd0, 1'b1},
    {1'b0, 16'h0020, 1'b0, 2'd1, 1'b1},
    {1'b0, 16'h0030, 1'b0, 2'd2, 1'b1},
    {1'b0, 16'h0040, 1'b0, 2'd3, 1'b1},
    {1'b0, 16'h0010, 1'b1, 2'd0, 1'b0},
    {1'b0, 16'h0050, 1'b0, 2'd1, 1'b1},
    {1'b1, 16'h0030, 1'b1, 2'd2, 1'b0},
    {1'b0, 16'h0060, 1'b0, 2'd2, 1'b1},
    {1'b0, 16'h0070, 1'b0, 2'd3, 1'b1},
    {1'b1, 16'h0099, 1'b0, 2'd0, 1'b0}
  };

  function automatic int st(input int i);
    return int'(buf_state[3*i +: 3]);
  endfunction
  function automatic int age(input int i);
    return int'(buf_age[2*i +: 2]);
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = 1'b0; fill_ready = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic req(input logic wr, input logic instr, input logic [1:0] mst,
                     input logic [AW-1:0] a);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_instr = instr; req_master = mst; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack();
    fill_ready = 1'b1;
    @(negedge clk);
    fill_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    for (int i = 0; i < NBUF; i++) begin
      chk("R1 state", st(i), 0);
      chk("R1 age", age(i), i);
    end
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 fill_valid", int'(fill_valid), 0);
    chk("R1 resp_valid", int'(resp_valid), 0);

    // Table walk: pool, no prefetch (R2 R3 R4 R5 R9)
    for (int v = 0; v < 10; v++) begin
      req(VEC[v][20], 1'b1, 2'd0, VEC[v][19:4]);
      chk("R2 resp_valid", int'(resp_valid), 1);
      chk("R2/R3/R4 resp_hit", int'(resp_hit), int'(VEC[v][3]));
      chk("R2/R3/R4 resp_buf", int'(resp_buf), int'(VEC[v][2:1]));
      chk("R5/R9 fill_valid", int'(fill_valid), int'(VEC[v][0]));
      if (VEC[v][0]) begin
        chk("R5 fill_addr", int'(fill_addr), int'(VEC[v][19:4]));
        chk("R5 fill_buf", int'(fill_buf), int'(VEC[v][2:1]));
        chk("R5 fill_pf", int'(fill_pf), 0);
        chk("R5 filling", st(int'(VEC[v][2:1])), 4);
        chk("R11 ready low", int'(req_ready), 0);
        ack();
        chk("R5 valid", st(int'(VEC[v][2:1])), 1);
        chk("R5 rank0", age(int'(VEC[v][2:1])), 0);
      end
      if (VEC[v][20] && VEC[v][3]) chk("R9 write hit invalidates", st(int'(VEC[v][2:1])), 0);
    end
    chk("R6 age b0", age(0), 3);
    chk("R6 age b1", age(1), 2);
    chk("R6 age b2", age(2), 1);
    chk("R6 age b3", age(3), 0);

    // Prefetch path (R7 R6 R2 R11)
    do_reset();
    cfg_pf_limit = 2'd1; cfg_ipf_en = 1'b1; cfg_dpf_en = 1'b1; cfg_mst_pf = 4'b0010;
    req(1'b0, 1'b1, 2'd1, 16'h0010); ack();
    req(1'b0, 1'b1, 2'd1, 16'h0010);
    chk("R2 hit", int'(resp_hit), 1);
    chk("R2 serving", st(0), 3);
    chk("R11 ready during serve", int'(req_ready), 0);
    chk("R7 pf fill", int'(fill_valid), 1);
    chk("R7 pf addr", int'(fill_addr), 16'h0011);
    chk("R7 pf buf", int'(fill_buf), 1);
    chk("R7 pf flag", int'(fill_pf), 1);
    ack();
    chk("R7 prefetched", st(1), 2);
    chk("R7 rank kept", age(1), 1);
    chk("R2 back to valid", st(0), 1);
    req(1'b0, 1'b1, 2'd1, 16'h0011);
    chk("R7 hit prefetched", int'(resp_hit), 1);
    chk("R7 promoted", age(1), 0);
    chk("R6 older shifts", age(0), 1);
    chk("R7 next pf addr", int'(fill_addr), 16'h0012);
    chk("R7 next pf buf", int'(fill_buf), 2);
    ack();

    // Prefetch gating (R8), 0x13 absent
    req(1'b0, 1'b1, 2'd2, 16'h0012);
    chk("R8 master off", int'(fill_valid), 0);
    cfg_pf_limit = 2'd0;
    req(1'b0, 1'b1, 2'd1, 16'h0012);
    chk("R8 limit zero", int'(fill_valid), 0);
    cfg_pf_limit = 2'd1; cfg_ipf_en = 1'b0;
    req(1'b0, 1'b1, 2'd1, 16'h0012);
    chk("R8 ipf off", int'(fill_valid), 0);
    cfg_ipf_en = 1'b1; cfg_buf_en = 1'b0;
    req(1'b0, 1'b1, 2'd1, 16'h0012);
    chk("R8 buf_en off", int'(fill_valid), 0);
    cfg_buf_en = 1'b1;
    req(1'b0, 1'b1, 2'd1, 16'h0012);
    chk("R8 all enabled", int'(fill_valid), 1);
    chk("R8 pf buf", int'(fill_buf), 3);
    ack();
    req(1'b1, 1'b1, 2'd1, 16'h0013);
    chk("R9 write hit", int'(resp_hit), 1);
    chk("R9 write no fill", int'(fill_valid), 0);
    chk("R9 invalidated", st(3), 0);
    req(1'b1, 1'b1, 2'd1, 16'h0077);
    chk("R9 write miss", int'(resp_hit), 0);
    chk("R9 write miss no fill", int'(fill_valid), 0);
    chk("R9 write miss b3 unchanged", st(3), 0);

    // Split 1 (R10 R4)
    do_reset();
    cfg_split = 2'd1; cfg_pf_limit = 2'd0;
    req(1'b0, 1'b0, 2'd0, 16'h0040);
    chk("R10 data to upper half", int'(resp_buf), 2); ack();
    req(1'b0, 1'b1, 2'd0, 16'h0050);
    chk("R10 instr to lower half", int'(resp_buf), 0); ack();
    req(1'b0, 1'b0, 2'd0, 16'h0050);
    chk("R10 no cross hit", int'(resp_hit), 0);
    chk("R10 data victim", int'(resp_buf), 3); ack();
    req(1'b0, 1'b0, 2'd0, 16'h0060);
    chk("R4 LRU within partition", int'(resp_buf), 2); ack();

    // Split 2 (R10 R7)
    do_reset();
    cfg_split = 2'd2; cfg_pf_limit = 2'd1; cfg_mst_pf = 4'b0001;
    req(1'b0, 1'b0, 2'd0, 16'h0040);
    chk("R10 data last buf", int'(resp_buf), 3); ack();
    req(1'b0, 1'b0, 2'd0, 16'h0040);
    chk("R2 data hit", int'(resp_hit), 1);
    chk("R7 no victim no pf", int'(fill_valid), 0);
    req(1'b0, 1'b0, 2'd0, 16'h0041);
    chk("R10 data reuses last", int'(resp_buf), 3); ack();
    req(1'b0, 1'b1, 2'd0, 16'h0041);
    chk("R10 instr miss", int'(resp_hit), 0);
    chk("R3 instr victim", int'(resp_buf), 0); ack();

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule